// File: doc/BRIEF.md
# Logical Device Configuration Register Bank

This block holds the configuration registers of a group of logical devices inside a legacy-free controller. A host reaches them through two byte-wide ports. A write to the index port picks a register. A write or read on the data port then reaches that register. The register at index 0x07 holds the logical device number. That number chooses which device's bank answers at indices 0x30 and above.

Each device stores three things: a 16-bit I/O base address, an interrupt select byte, and a single activate bit. The keyboard device also has a second interrupt select byte. The activate bit also serves as the power-control bit, so writing one always writes the other. Every location that is not implemented reads zero and drops writes.

Each device has a combinational on output. The serial device's on output is further gated by a bit of an external microcontroller disable register. Each device also has a registered hit output. It shows that a host I/O cycle fell inside the device's 8-byte window, and only while the device is on and its base address lies in the permitted range.

Top module: `ldcfg_bank`

## Requirements
- R1: A write with `host_sel`=0 loads the index register from `host_wdata`. A read with `host_sel`=0 returns the index, which resets to 0.
- R2: Index 0x07 holds the logical device number and resets to 0. When the number is NUM_DEV or above, every bank index (0x30 and up) reads 0 and ignores writes, and no device's stored values change.
- R3: Bank index 0x60 holds base address bits [15:8] and 0x61 holds bits [7:0], separately for each device. Both reset to 0.
- R4: Bank index 0x70 is an interrupt select byte in every device. It resets to 0xC0: bit 7 = edge triggered, bit 6 = active-high, bits [3:0] = line number.
- R5: Bank index 0x72 is a second interrupt select byte. It exists only in device KBD_DEV (7), where it resets to 0xC0. In every other device it reads 0 and ignores writes.
- R6: These locations read 0 and ignore writes: every index below 0x30 other than 0x07, every bank index other than 0x30, 0x60, 0x61, 0x70 and 0x72 (for example 0x40, 0x71 and 0xFF), and bits [7:1] of 0x30.
- R7: Bit 0 of bank index 0x30 is one stored bit that acts as both the activate bit and the power-control bit. It resets to 0 and reads back as written.
- R8: `dev_on[i]` equals device i's activate bit. For device SER_DEV (4) the activate bit is also ANDed with `mcu_dis[6]`. No other bit of `mcu_dis` has any effect.
- R9: `io_hit[i]` rises one clock after a cycle with `io_valid`=1 when all of these hold: `io_addr[15:3]` equals base[15:3], the device is on, and the base is in range. Otherwise `io_hit[i]` is 0.
- R10: A base address outside 0x0100..0x0FF8 inclusive never produces a hit, even when the address matches and the device is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 = index port, 1 = data port |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data of the selected port |
| mcu_dis | input | 8 | Microcontroller disable register |
| io_valid | input | 1 | Host I/O cycle present |
| io_addr | input | 16 | Host I/O address |
| dev_on | output | NUM_DEV | Per-device on state |
| io_hit | output | NUM_DEV | Registered per-device address hit |

## Verification
The hardest case to reach is a hit that is suppressed. Only one of its conditions fails while all the others hold, and the failing one must be set up through several index/data writes before the probe. The stimulus programs a matching base address and the activate bit, then breaks exactly one condition before each probe: it moves the base out of range, clears the activate bit, or drops the serial gate bit. Bank isolation is shown by writing through an out-of-range device number. The bench then selects a real device again and reads back that device's unchanged base address.

// File: rtl/ldcfg_pkg.sv
package ldcfg_pkg;
    localparam logic [7:0] IDX_LDN       = 8'h07;
    localparam logic [7:0] IDX_BANK_LOW  = 8'h30;
    localparam logic [7:0] IDX_ACT       = 8'h30;
    localparam logic [7:0] IDX_BASE_HI   = 8'h60;
    localparam logic [7:0] IDX_BASE_LO   = 8'h61;
    localparam logic [7:0] IDX_IRQ0      = 8'h70;
    localparam logic [7:0] IDX_IRQ1      = 8'h72;
    localparam logic [7:0] IRQ_RST       = 8'hC0;

    typedef struct packed {
        logic       act;
        logic [7:0] base_hi;
        logic [7:0] base_lo;
        logic [7:0] irq0;
        logic [7:0] irq1;
        logic       hit;
    } dev_state_t;

    typedef struct packed {
        logic [7:0] index;
        logic [7:0] ldn;
    } host_state_t;
endpackage

// File: rtl/ldcfg_dev.sv
module ldcfg_dev
    import ldcfg_pkg::*;
#(
    parameter bit          HAS_IRQ1 = 1'b0,
    parameter bit          GATED    = 1'b0,
    parameter int          WIN_BITS = 3,
    parameter logic [15:0] BASE_MIN = 16'h0100,
    parameter logic [15:0] BASE_MAX = 16'h0FF8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  idx,
    input  logic [7:0]  wdata,
    input  logic        gate_bit,
    input  logic        io_valid,
    input  logic [15:0] io_addr,
    output logic [7:0]  rd_data,
    output logic        dev_on,
    output logic        hit
);
    localparam logic [7:0] IRQ1_RST = HAS_IRQ1 ? IRQ_RST : 8'h00;

    dev_state_t s_d, s_q;
    logic [15:0] base;
    logic        in_range;

    assign base     = {s_q.base_hi, s_q.base_lo};
    assign in_range = (base >= BASE_MIN) && (base <= BASE_MAX);
    assign dev_on   = s_q.act && (!GATED || gate_bit);
    assign hit      = s_q.hit;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (idx)
                IDX_ACT:     s_d.act     = wdata[0];
                IDX_BASE_HI: s_d.base_hi = wdata;
                IDX_BASE_LO: s_d.base_lo = wdata;
                IDX_IRQ0:    s_d.irq0    = wdata;
                IDX_IRQ1:    if (HAS_IRQ1) s_d.irq1 = wdata;
                default:     ;
            endcase
        end
        s_d.hit = io_valid && dev_on && in_range &&
                  (io_addr[15:WIN_BITS] == base[15:WIN_BITS]);
    end

    always_comb begin
        case (idx)
            IDX_ACT:     rd_data = {7'd0, s_q.act};
            IDX_BASE_HI: rd_data = s_q.base_hi;
            IDX_BASE_LO: rd_data = s_q.base_lo;
            IDX_IRQ0:    rd_data = s_q.irq0;
            IDX_IRQ1:    rd_data = HAS_IRQ1 ? s_q.irq1 : 8'h00;
            default:     rd_data = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{act: 1'b0, base_hi: 8'h00, base_lo: 8'h00,
                     irq0: IRQ_RST, irq1: IRQ1_RST, hit: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/ldcfg_bank.sv
module ldcfg_bank
    import ldcfg_pkg::*;
#(
    parameter int          NUM_DEV      = 8,
    parameter int          KBD_DEV      = 7,
    parameter int          SER_DEV      = 4,
    parameter int          SER_GATE_BIT = 6,
    parameter int          WIN_BITS     = 3,
    parameter logic [15:0] BASE_MIN     = 16'h0100,
    parameter logic [15:0] BASE_MAX     = 16'h0FF8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic               host_sel,
    input  logic [7:0]         host_wdata,
    output logic [7:0]         host_rdata,
    input  logic [7:0]         mcu_dis,
    input  logic               io_valid,
    input  logic [15:0]        io_addr,
    output logic [NUM_DEV-1:0] dev_on,
    output logic [NUM_DEV-1:0] io_hit
);
    localparam int         LDN_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
    localparam logic [7:0] NUM_DEVB = 8'(NUM_DEV);

    host_state_t h_d, h_q;
    logic        bank_ok;
    logic        bank_idx;
    logic [7:0]  dev_rd [NUM_DEV];

    assign bank_ok  = (h_q.ldn < NUM_DEVB);
    assign bank_idx = (h_q.index >= IDX_BANK_LOW);

    always_comb begin
        h_d = h_q;
        if (host_we && !host_sel) begin
            h_d.index = host_wdata;
        end else if (host_we && host_sel && (h_q.index == IDX_LDN)) begin
            h_d.ldn = host_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    always_comb begin
        if (!host_sel) begin
            host_rdata = h_q.index;
        end else if (h_q.index == IDX_LDN) begin
            host_rdata = h_q.ldn;
        end else if (bank_idx && bank_ok) begin
            host_rdata = dev_rd[h_q.ldn[LDN_W-1:0]];
        end else begin
            host_rdata = 8'h00;
        end
    end

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
        logic wr_en_i;
        assign wr_en_i = host_we && host_sel && bank_idx && (h_q.ldn == 8'(i));
        ldcfg_dev #(
            .HAS_IRQ1 (i == KBD_DEV),
            .GATED    (i == SER_DEV),
            .WIN_BITS (WIN_BITS),
            .BASE_MIN (BASE_MIN),
            .BASE_MAX (BASE_MAX)
        ) u_dev (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en_i),
            .idx      (h_q.index),
            .wdata    (host_wdata),
            .gate_bit (mcu_dis[SER_GATE_BIT]),
            .io_valid (io_valid),
            .io_addr  (io_addr),
            .rd_data  (dev_rd[i]),
            .dev_on   (dev_on[i]),
            .hit      (io_hit[i])
        );
    end
endmodule

// File: rtl/ldcfg_bank_chk.sv
module ldcfg_bank_chk #(
    parameter int NUM_DEV      = 8,
    parameter int SER_DEV      = 4,
    parameter int SER_GATE_BIT = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_we,
    input logic               host_sel,
    input logic [7:0]         host_wdata,
    input logic [7:0]         host_rdata,
    input logic [7:0]         mcu_dis,
    input logic               io_valid,
    input logic [NUM_DEV-1:0] dev_on,
    input logic [NUM_DEV-1:0] io_hit
);
    AST_INDEX_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(host_we && !host_sel) && !host_sel) |-> (host_rdata == $past(host_wdata))); // R1

    AST_SER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !mcu_dis[SER_GATE_BIT] |-> !dev_on[SER_DEV]); // R8

    AST_HIT_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|io_hit) |-> $past(io_valid)); // R9

    AST_HIT_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (|io_hit) |-> ((io_hit & ~$past(dev_on)) == '0)); // R9
endmodule

bind ldcfg_bank ldcfg_bank_chk #(
    .NUM_DEV      (NUM_DEV),
    .SER_DEV      (SER_DEV),
    .SER_GATE_BIT (SER_GATE_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .mcu_dis    (mcu_dis),
    .io_valid   (io_valid),
    .dev_on     (dev_on),
    .io_hit     (io_hit)
);

// File: tb/ldcfg_bank_bench.sv
module ldcfg_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic [7:0]  mcu_dis = 8'h00;
    logic        io_valid = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic [7:0]  dev_on;
    logic [7:0]  io_hit;

    always #4 clk = ~clk;

    ldcfg_bank u_ldcfg_bank (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mcu_dis(mcu_dis),
        .io_valid(io_valid), .io_addr(io_addr), .dev_on(dev_on), .io_hit(io_hit)
    );

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    logic  chk = 1'b0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    always @(negedge clk) begin
        if (chk && q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = q.pop_front();
            case (it.kind)
                0:       act = host_rdata;
                1:       act = dev_on;
                default: act = io_hit;
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push(input int kind, input logic [7:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        q.push_back(it);
        chk = 1'b1;
        @(posedge clk); #1;
        chk = 1'b0;
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] data);
        @(posedge clk); #1;
        host_we = 1'b1; host_sel = 1'b0; host_wdata = idx;
        @(posedge clk); #1;
        host_sel = 1'b1; host_wdata = data;
        @(posedge clk); #1;
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] idx, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        host_we = 1'b1; host_sel = 1'b0; host_wdata = idx;
        @(posedge clk); #1;
        host_we = 1'b0; host_sel = 1'b1;
        push(0, exp, tag);
    endtask

    task automatic probe(input logic [15:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        io_valid = 1'b1; io_addr = a;
        @(posedge clk); #1;
        io_valid = 1'b0;
        push(2, exp, tag);
    endtask

    task automatic exp_on(input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        push(1, exp, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // reset state
        @(posedge clk); #1;
        host_sel = 1'b0;
        push(0, 8'h00, "R1 index reset");
        rd(8'h07, 8'h00, "R2 ldn reset");
        rd(8'h60, 8'h00, "R3 base hi reset");
        rd(8'h70, 8'hC0, "R4 irq0 reset");
        rd(8'h72, 8'h00, "R5 irq1 absent dev0");
        exp_on(8'h00, "R7 activate reset");
        // index readback
        @(posedge clk); #1;
        host_we = 1'b1; host_sel = 1'b0; host_wdata = 8'h5A;
        @(posedge clk); #1;
        host_we = 1'b0;
        push(0, 8'h5A, "R1 index readback");
        // base registers per device
        wr(8'h07, 8'h01);
        wr(8'h60, 8'h03);
        wr(8'h61, 8'hF8);
        rd(8'h60, 8'h03, "R3 base hi dev1");
        rd(8'h61, 8'hF8, "R3 base lo dev1");
        wr(8'h07, 8'h02);
        rd(8'h61, 8'h00, "R3 dev2 separate");
        wr(8'h70, 8'h25);
        rd(8'h70, 8'h25, "R4 irq0 write dev2");
        // reserved
        wr(8'h40, 8'hFF);
        rd(8'h40, 8'h00, "R6 0x40");
        wr(8'h71, 8'hFF);
        rd(8'h71, 8'h00, "R6 0x71");
        wr(8'hFF, 8'hFF);
        rd(8'hFF, 8'h00, "R6 0xFF");
        wr(8'h10, 8'hFF);
        rd(8'h10, 8'h00, "R6 global 0x10");
        wr(8'h72, 8'h0A);
        rd(8'h72, 8'h00, "R5 irq1 ignored dev2");
        // keyboard device second select
        wr(8'h07, 8'h07);
        rd(8'h72, 8'hC0, "R5 irq1 reset kbd");
        wr(8'h72, 8'h05);
        rd(8'h72, 8'h05, "R5 irq1 write kbd");
        // activate / on
        wr(8'h07, 8'h01);
        wr(8'h30, 8'hFF);
        rd(8'h30, 8'h01, "R6 0x30 upper bits");
        exp_on(8'h02, "R7 activate dev1");
        // hits
        probe(16'h03FA, 8'h02, "R9 hit in window");
        probe(16'h0400, 8'h00, "R9 outside window");
        wr(8'h60, 8'h00);
        wr(8'h61, 8'h50);
        probe(16'h0050, 8'h00, "R10 base below range");
        wr(8'h60, 8'h10);
        wr(8'h61, 8'h00);
        probe(16'h1000, 8'h00, "R10 base above range");
        wr(8'h60, 8'h03);
        wr(8'h61, 8'hF8);
        wr(8'h30, 8'h00);
        exp_on(8'h00, "R7 deactivate dev1");
        probe(16'h03F8, 8'h00, "R9 device off");
        // serial gating
        wr(8'h07, 8'h04);
        wr(8'h30, 8'h01);
        exp_on(8'h00, "R8 serial gated off");
        mcu_dis = 8'h40;
        exp_on(8'h10, "R8 serial gate set");
        mcu_dis = 8'hBF;
        exp_on(8'h00, "R8 other bits no effect");
        mcu_dis = 8'h00;
        // out-of-range device number
        wr(8'h07, 8'h09);
        wr(8'h60, 8'hAA);
        rd(8'h60, 8'h00, "R2 bank absent reads 0");
        wr(8'h07, 8'h01);
        rd(8'h60, 8'h03, "R2 dev1 untouched");
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule